// File: doc/BRIEF.md
# Stack-Relative Word Store Unit with Displacement Prefixes

This block runs a single kind of 16-bit instruction: a word store whose address is the stack pointer plus an immediate displacement. Instruction words arrive one per accepted valid/ready handshake, along with the current stack pointer. The unit drives the select lines of a register-file read port and takes back the 32-bit register value. It writes one 32-bit word through a memory write port that carries an address, data and byte strobes.

Prefix words can come before the store to widen its displacement. With no prefix, the 6-bit field counts words and is shifted left by two. One prefix puts 13 more bits above the field, which is then used unscaled. Two prefixes build a full 32-bit displacement. Any other instruction word, and the store itself, discards pending prefixes. An extended store whose address is not word aligned is dropped and a one-cycle error pulse is raised.

Top module: `sp_store_unit`

## Requirements
- R1: A word is a store only when bits 15:10 equal 6'b010111. Bits 9:4 then hold the 6-bit immediate and bits 3:0 select the source register, which is driven on `regSel` while the word is presented. Any other opcode never causes a memory write.
- R2: A store with no pending prefix writes to `stackPtr + imm*4`.
- R3: A prefix word has bits 15:13 equal to 3'b110, and bits 12:0 are its payload. After exactly one prefix, the store uses the displacement {13'b0, payload, imm}, with the immediate unscaled.
- R4: After two prefixes, the store uses the 32-bit displacement {first payload, second payload, imm}.
- R5: The address sum wraps modulo 2^32.
- R6: The written data is the full 32-bit value of the selected register. `memStrb` is 4'b1111 while `memWrEn` is high and 4'b0000 otherwise.
- R7: A store is accepted in one cycle and writes in the next. In that second cycle `memWrEn` is high for exactly one cycle and `instrReady` is low. In the cycle after that, `instrReady` is high again.
- R8: An extended store (one or two prefixes) whose computed address has nonzero bits 1:0 raises `misalignErr` for one cycle in the write cycle and does not assert `memWrEn`.
- R9: Any accepted word that is not a prefix clears the pending prefixes. This includes a store, so the next store is unextended.
- R10: After reset `instrReady` is high, `memWrEn`, `memStrb` and `misalignErr` are low, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word valid |
| instrWord | input | 16 | Instruction word |
| instrReady | output | 1 | Unit can accept a word |
| stackPtr | input | 32 | Current stack pointer |
| regSel | output | 4 | Register-file read select |
| regData | input | 32 | Register-file read data |
| memWrEn | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory write address |
| memWrData | output | 32 | Memory write data |
| memStrb | output | 4 | Byte strobes |
| misalignErr | output | 1 | Misaligned extended store pulse |

## Verification
The assertions check the per-cycle rules on every cycle:
- a write lasts one cycle, holds ready low, and follows an accepted store opcode;
- the strobes follow the enable;
- written data matches the register value read one cycle earlier;
- the error pulse never coincides with a write and only occurs on a misaligned address.

The displacement arithmetic can only be shown by the bench's scenarios. This covers scaling, the concatenation of one or two prefixes, wrap-around, and the clearing of prefixes by other words or by a store. Those depend on the history of prefix words.

// File: rtl/spstore_pkg.sv
package spstore_pkg;
  localparam int INSTR_W = 16;

  typedef struct packed {
    logic pushPfx;   // accepted word is a prefix
    logic clearPfx;  // accepted word is not a prefix
    logic capture;   // accepted word is a store: latch address/data
    logic execute;   // second cycle of a store
  } ctrlStrobes_t;
endpackage

// File: rtl/spstore_ctrl.sv
module spstore_ctrl
  import spstore_pkg::*;
#(
  parameter logic [5:0] STORE_OP = 6'b010111,
  parameter logic [2:0] PFX_OP   = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               instrReady,
  output ctrlStrobes_t       strobes
);
  localparam int OP_HI = INSTR_W - 1;

  typedef enum logic [0:0] {ST_IDLE, ST_EXEC} state_t;
  state_t state, stateNext;

  logic accept, isStore, isPfx;

  assign isStore    = (instrWord[OP_HI -: 6] == STORE_OP);
  assign isPfx      = (instrWord[OP_HI -: 3] == PFX_OP);
  assign instrReady = (state == ST_IDLE);
  assign accept     = instrValid && instrReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept && isStore) stateNext = ST_EXEC;
      ST_EXEC: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes          = '0;
    strobes.pushPfx  = accept && isPfx;
    strobes.clearPfx = accept && !isPfx;
    strobes.capture  = accept && isStore;
    strobes.execute  = (state == ST_EXEC);
  end
endmodule

// File: rtl/spstore_dp.sv
module spstore_dp
  import spstore_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PFX_W    = 13,
  parameter int IMM_W    = 6,
  parameter int SCALE_SH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  stackPtr,
  input  logic [DATA_W-1:0]  regData,
  output logic               memWrEn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic               misalignErr
);
  localparam int STRB_W = DATA_W / 8;
  localparam int IMM_LO = 4;
  localparam int ALIGN_W = $clog2(STRB_W);

  logic [1:0]        pfxCnt;
  logic [PFX_W-1:0]  pfxHi, pfxLo;
  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              extQ, badAlign;

  assign imm = instrWord[IMM_LO +: IMM_W];

  // Prefix history: the newest payload sits in pfxLo, the older one in pfxHi.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfxCnt <= '0;
      pfxHi  <= '0;
      pfxLo  <= '0;
    end else if (strobes.pushPfx) begin
      pfxHi  <= pfxLo;
      pfxLo  <= instrWord[PFX_W-1:0];
      pfxCnt <= (pfxCnt == 2'd2) ? 2'd2 : pfxCnt + 2'd1;
    end else if (strobes.clearPfx) begin
      pfxCnt <= '0;
    end
  end

  always_comb begin
    case (pfxCnt)
      2'd0:    disp = ADDR_W'({imm, {SCALE_SH{1'b0}}});
      2'd1:    disp = ADDR_W'({pfxLo, imm});
      default: disp = ADDR_W'({pfxHi, pfxLo, imm});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      extQ  <= 1'b0;
    end else if (strobes.capture) begin
      addrQ <= stackPtr + disp;
      dataQ <= regData;
      extQ  <= (pfxCnt != 2'd0);
    end
  end

  assign badAlign    = extQ && (addrQ[ALIGN_W-1:0] != '0);
  assign memWrEn     = strobes.execute && !badAlign;
  assign misalignErr = strobes.execute && badAlign;
  assign memStrb     = memWrEn ? {STRB_W{1'b1}} : '0;
  assign memAddr     = addrQ;
  assign memWrData   = dataQ;
endmodule

// File: rtl/sp_store_unit.sv
module sp_store_unit
  import spstore_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_SEL = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [15:0]         instrWord,
  output logic                instrReady,
  input  logic [ADDR_W-1:0]   stackPtr,
  output logic [REG_SEL-1:0]  regSel,
  input  logic [DATA_W-1:0]   regData,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic                misalignErr
);
  ctrlStrobes_t strobes;

  assign regSel = instrWord[REG_SEL-1:0];

  spstore_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .strobes(strobes)
  );

  spstore_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instrWord(instrWord),
    .stackPtr(stackPtr), .regData(regData), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .memStrb(memStrb),
    .misalignErr(misalignErr)
  );
endmodule

// File: rtl/spstore_chk.sv
module spstore_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic        instrReady,
  input logic [31:0] regData,
  input logic        memWrEn,
  input logic [31:0] memAddr,
  input logic [31:0] memWrData,
  input logic [3:0]  memStrb,
  input logic        misalignErr
);
  assert_wr_after_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(instrValid && instrReady && instrWord[15:10] == 6'b010111));
  assert_strb_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memStrb == 4'hF);
  assert_strb_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEn |-> memStrb == 4'h0);
  assert_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memWrData == $past(regData));
  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !instrReady);
  assert_no_wr_on_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr |-> !memWrEn && memAddr[1:0] != 2'b00);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr |=> !misalignErr);
endmodule

bind sp_store_unit spstore_chk chk_i (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .instrReady(instrReady), .regData(regData), .memWrEn(memWrEn),
  .memAddr(memAddr), .memWrData(memWrData), .memStrb(memStrb),
  .misalignErr(misalignErr)
);

// File: tb/sp_store_unit_tb.sv
module sp_store_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = 16'h0;
  logic        instrReady;
  logic [31:0] stackPtr = 32'h0;
  logic [3:0]  regSel;
  logic [31:0] regData;
  logic        memWrEn;
  logic [31:0] memAddr, memWrData;
  logic [3:0]  memStrb;
  logic        misalignErr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] regVal(input logic [3:0] i);
    return 32'hA5000000 ^ ({28'h0, i} * 32'h01030507);
  endfunction

  assign regData = regVal(regSel);

  sp_store_unit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .stackPtr(stackPtr), .regSel(regSel),
    .regData(regData), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memStrb(memStrb), .misalignErr(misalignErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one word; returns at the negedge after it was accepted.
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = w;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    instrWord  = 16'h0;
  endtask

  function automatic logic [15:0] storeWord(input logic [5:0] imm, input logic [3:0] rs);
    return {6'b010111, imm, rs};
  endfunction

  function automatic logic [15:0] pfxWord(input logic [12:0] p);
    return {3'b110, p};
  endfunction

  // Store with n prefixes already issued by caller; checks write cycle and after.
  task automatic doStore(input string tag, input logic [31:0] sp, input int n,
                         input logic [12:0] hi, input logic [12:0] lo,
                         input logic [5:0] imm, input logic [3:0] rs);
    logic [31:0] disp, exp;
    logic mis;
    if (n == 0)      disp = {24'h0, imm, 2'b00};
    else if (n == 1) disp = {13'h0, lo, imm};
    else             disp = {hi, lo, imm};
    exp = sp + disp;
    mis = (n != 0) && (exp[1:0] != 2'b00);
    stackPtr = sp;
    issue(storeWord(imm, rs));
    check({tag, " wrEn"}, {31'h0, memWrEn}, {31'h0, !mis});
    check({tag, " misalign"}, {31'h0, misalignErr}, {31'h0, mis});
    check({tag, " ready low R7"}, {31'h0, instrReady}, 32'h0);
    if (!mis) begin
      check({tag, " addr"}, memAddr, exp);
      check({tag, " data R6"}, memWrData, regVal(rs));
      check({tag, " strb R6"}, {28'h0, memStrb}, 32'hF);
    end else begin
      check({tag, " strb off R8"}, {28'h0, memStrb}, 32'h0);
    end
    @(negedge clk);
    check({tag, " wrEn drop R7"}, {31'h0, memWrEn}, 32'h0);
    check({tag, " err drop R8"}, {31'h0, misalignErr}, 32'h0);
    check({tag, " ready back R7"}, {31'h0, instrReady}, 32'h1);
  endtask

  task automatic testReset();
    check("R10 ready", {31'h0, instrReady}, 32'h1);
    check("R10 wrEn", {31'h0, memWrEn}, 32'h0);
    check("R10 strb", {28'h0, memStrb}, 32'h0);
    check("R10 err", {31'h0, misalignErr}, 32'h0);
    doStore("R10 no pfx", 32'h0000_2000, 0, 13'h0, 13'h0, 6'd1, 4'd2);
  endtask

  task automatic testPlain();
    doStore("R2 a", 32'h0000_1000, 0, 13'h0, 13'h0, 6'd5, 4'd3);
    doStore("R2 b", 32'h8000_0004, 0, 13'h0, 13'h0, 6'd63, 4'd15);
    doStore("R2 c", 32'h0000_0000, 0, 13'h0, 13'h0, 6'd0, 4'd0);
  endtask

  task automatic testRegSel();
    @(negedge clk);
    instrWord = storeWord(6'd9, 4'd11);
    #1 check("R1 regSel", {28'h0, regSel}, 32'd11);
    instrWord = 16'h0;
  endtask

  task automatic testOnePfx();
    issue(pfxWord(13'h1ABC));
    doStore("R3 a", 32'h0000_1000, 1, 13'h0, 13'h1ABC, 6'h08, 4'd4);
    issue(pfxWord(13'h0001));
    doStore("R3 b", 32'h0000_0000, 1, 13'h0, 13'h0001, 6'h3C, 4'd7);
  endtask

  task automatic testTwoPfx();
    issue(pfxWord(13'h1FFF));
    issue(pfxWord(13'h0001));
    doStore("R4 a", 32'h0000_0100, 2, 13'h1FFF, 13'h0001, 6'h04, 4'd5);
    issue(pfxWord(13'h0123));
    issue(pfxWord(13'h1456));
    doStore("R4 b", 32'h1000_0000, 2, 13'h0123, 13'h1456, 6'h00, 4'd9);
  endtask

  task automatic testWrap();
    doStore("R5 plain", 32'hFFFF_FFF0, 0, 13'h0, 13'h0, 6'd8, 4'd1);
    issue(pfxWord(13'h1FFF));
    issue(pfxWord(13'h1FFF));
    doStore("R5 ext", 32'h0000_0100, 2, 13'h1FFF, 13'h1FFF, 6'h3C, 4'd6);
  endtask

  task automatic testMisalign();
    issue(pfxWord(13'h0010));
    doStore("R8 one", 32'h0000_1000, 1, 13'h0, 13'h0010, 6'h02, 4'd8);
    issue(pfxWord(13'h0002));
    issue(pfxWord(13'h0003));
    doStore("R8 two", 32'h0000_1001, 2, 13'h0002, 13'h0003, 6'h04, 4'd10);
  endtask

  task automatic testClear();
    issue(pfxWord(13'h0777));
    issue(16'h0000);
    doStore("R9 other", 32'h0000_4000, 0, 13'h0, 13'h0, 6'd3, 4'd12);
    issue(pfxWord(13'h0555));
    doStore("R9 first", 32'h0000_4000, 1, 13'h0, 13'h0555, 6'h10, 4'd13);
    doStore("R9 after store", 32'h0000_4000, 0, 13'h0, 13'h0, 6'd2, 4'd14);
  endtask

  task automatic testNonStore();
    issue(16'h5800 | 16'h0013);
    check("R1 no write opcode 010110", {31'h0, memWrEn}, 32'h0);
    check("R1 ready stays", {31'h0, instrReady}, 32'h1);
    issue(16'h6000);
    check("R1 no write opcode 011000", {31'h0, memWrEn}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testRegSel();
    testOnePfx();
    testTwoPfx();
    testWrap();
    testMisalign();
    testClear();
    testNonStore();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule